// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames in a circular buffer held in local packet memory. The buffer is divided into 256-byte pages. Two programmable page numbers bound the ring: a first page (inclusive) and a last page (exclusive). The block keeps a current-page pointer that marks where the next frame lands. Software owns a boundary page that marks the oldest page it has not yet consumed. Every page number becomes a byte address by shifting it left by eight bits.

When a frame starts, the block decides at once whether to take it. A frame is refused if the controller is stopped, if the ring is empty or inverted, or if the free space up to the boundary is too small for a maximum-size frame. A refused frame is consumed and discarded. An accepted frame streams into memory one byte per clock, beginning four bytes into its first page, and the write address wraps at the end of the ring. After the last data byte the block writes a four-byte header into the first page. The header carries the status, the link to the next free page and the stored length. The current page then moves to that link page and a receive interrupt flag is raised.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, busy_o, mem_we_o, done_o and rx_irq_o are 0 and cur_pg_o is 0.
- R2: A frame's header starts at byte address cur_pg_o*256, and its data starts at cur_pg_o*256+4.
- R3: A frame that starts while rx_stop_i is 1, or while ring_last_pg_i <= ring_first_pg_i, is discarded: it causes no memory write, cur_pg_o does not change and rx_irq_o does not change.
- R4: Free space in bytes is (bnd-cur)*256 when cur < bnd, and otherwise ((last-first)-(cur-bnd))*256. The frame is discarded as in R3 when free space is below MAX_FRAME+4 (1518 by default) and accepted when it is at or above that value.
- R5: The header bytes are written at offsets 0, 1, 2 and 3 from the frame base, in that order. Offset 0 holds the status, offset 1 the next page, offset 2 the low byte of (length+4) and offset 3 the high byte. All data bytes are written before the header.
- R6: The status byte is 0x01, or 0x21 when bit 0 of the first frame byte is 1.
- R7: The next page is cur + ceil((length+8)/256). If the result is >= last, (last-first) is subtracted from it.
- R8: When the data write address reaches last*256, it continues at first*256.
- R9: When the last header byte is written, cur_pg_o takes the next-page value and rx_irq_o becomes 1. A pulse on irq_clr_i clears rx_irq_o when no frame completes in the same cycle.
- R10: Writes occur at most one byte per clock. busy_o stays high from the first accepted byte until the final header write. done_o is high for exactly one cycle, on the final header write, and once per accepted frame. Gaps in in_valid_i are allowed. A frame of one byte (start and end on the same beat) is stored.
- R11: When cur_pg_o is >= END_PG, the frame is placed at ring_first_pg_i. The free-space check still uses the unadjusted current page.
- R12: cur_ld_i loads cur_ld_pg_i into the current page only when the block is idle and the value is below END_PG. In every other case the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_stop_i | input | 1 | Controller stopped; refuse new frames |
| ring_first_pg_i | input | 8 | First page of the ring |
| ring_last_pg_i | input | 8 | Page just past the end of the ring |
| bnd_pg_i | input | 8 | Host boundary page |
| cur_ld_i | input | 1 | Load the current page |
| cur_ld_pg_i | input | 8 | Value for the current-page load |
| irq_clr_i | input | 1 | Clear the receive interrupt flag |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Frame byte |
| in_len_i | input | 16 | Frame length in bytes, sampled with the first byte |
| busy_o | output | 1 | Frame in progress; no new frame may start |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| done_o | output | 1 | One-cycle pulse on the final header write |
| cur_pg_o | output | 8 | Current page pointer |
| rx_irq_o | output | 1 | Receive interrupt status flag |

## Verification
A wrong free-space or range decision shows up on the first cycle after a frame starts: either a write appears where none should, or an expected write is missing. A wrong base or a wrong wrap point shows up as a bad address on the very write where the error occurs, so every write is compared against an independently computed address and data sequence. A bad next-page link shows up twice: once in header byte 1, and again when cur_pg_o is checked after done_o. A stale current page would then move every later frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_HDR
  } rxr_state_e;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned HDR_LEN_W = 16;
endpackage

// File: rtl/rxr_admit.sv
module rxr_admit #(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned END_PG    = 128,
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic             stop_i,
  input  logic [PG_W-1:0]  first_pg_i,
  input  logic [PG_W-1:0]  last_pg_i,
  input  logic [PG_W-1:0]  bnd_pg_i,
  input  logic [PG_W-1:0]  cur_pg_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic [PG_W-1:0]  base_pg_o,
  output logic [PG_W-1:0]  next_pg_o
);
  localparam int unsigned FREE_W = PG_W + 2;
  localparam int unsigned FB_W   = FREE_W + 8;
  localparam int unsigned NX_W   = PG_W + LEN_W + 1;
  localparam logic signed [FB_W-1:0] NEED_B = FB_W'(MAX_FRAME + 4);
  localparam logic [PG_W:0] END_V = (PG_W+1)'(END_PG);
  // header (4) + trailing CRC room (4) + round-up to a page (255)
  localparam logic [LEN_W+1:0] ALLOC_ADD = (LEN_W+2)'(263);

  logic signed [FREE_W-1:0] free_pg;
  logic signed [FB_W-1:0]   free_b;
  logic [LEN_W+1:0]         alloc_b;
  logic [NX_W-1:0]          next_raw;

  always_comb begin
    if (cur_pg_i < bnd_pg_i) begin
      free_pg = $signed({2'b00, bnd_pg_i}) - $signed({2'b00, cur_pg_i});
    end else begin
      free_pg = ($signed({2'b00, last_pg_i}) - $signed({2'b00, first_pg_i}))
              - ($signed({2'b00, cur_pg_i}) - $signed({2'b00, bnd_pg_i}));
    end
    free_b = {free_pg, 8'h00};
    ok_o   = !stop_i && (last_pg_i > first_pg_i) && (free_b >= NEED_B);

    base_pg_o = ({1'b0, cur_pg_i} >= END_V) ? first_pg_i : cur_pg_i;

    alloc_b  = {2'b00, len_i} + ALLOC_ADD;
    next_raw = NX_W'(base_pg_o) + NX_W'(alloc_b >> 8);
    if (next_raw >= NX_W'(last_pg_i)) begin
      next_raw = next_raw - NX_W'(last_pg_i - first_pg_i);
    end
    next_pg_o = next_raw[PG_W-1:0];
  end
endmodule

// File: rtl/rxr_wrap_ctr.sv
module rxr_wrap_ctr #(
  parameter int unsigned PG_W = 8,
  localparam int unsigned ADDR_W = PG_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic [PG_W-1:0]   first_pg_i,
  input  logic [PG_W-1:0]   last_pg_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a,
                                                  input logic [PG_W-1:0] f,
                                                  input logic [PG_W-1:0] l);
    logic [ADDR_W-1:0] n;
    n = a + ADDR_W'(1);
    if (n == {l, 8'h00}) n = {f, 8'h00};
    return n;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= wrap_inc(load_addr_i, first_pg_i, last_pg_i);
    end else if (step_i) begin
      addr_q <= wrap_inc(addr_q, first_pg_i, last_pg_i);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned PG_W      = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned END_PG    = 128,
  parameter int unsigned MAX_FRAME = 1514,
  localparam int unsigned ADDR_W   = PG_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_stop_i,
  input  logic [PG_W-1:0]   ring_first_pg_i,
  input  logic [PG_W-1:0]   ring_last_pg_i,
  input  logic [PG_W-1:0]   bnd_pg_i,
  input  logic              cur_ld_i,
  input  logic [PG_W-1:0]   cur_ld_pg_i,
  input  logic              irq_clr_i,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [7:0]        in_data_i,
  input  logic [LEN_W-1:0]  in_len_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              done_o,
  output logic [PG_W-1:0]   cur_pg_o,
  output logic              rx_irq_o
);
  localparam logic [PG_W:0] END_V = (PG_W+1)'(END_PG);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(HDR_BYTES);

  rxr_state_e        state_q;
  logic [PG_W-1:0]   cur_q, next_q;
  logic [ADDR_W-1:0] base_q, addr_q, ctr_addr, base_addr;
  logic [HDR_LEN_W-1:0] tot_q;
  logic [7:0]        stat_q, wdata_q, hdr_byte;
  logic [1:0]        hcnt_q;
  logic              we_q, done_q, irq_q;
  logic              ok, sof_hit, ctr_load, ctr_step;
  logic [PG_W-1:0]   base_pg, next_pg;

  assign sof_hit  = (state_q == ST_IDLE) && in_valid_i && in_sof_i;
  assign ctr_load = sof_hit && ok;
  assign ctr_step = (state_q == ST_DATA) && in_valid_i;
  assign base_addr = {base_pg, 8'h00};

  rxr_admit #(
    .PG_W(PG_W), .LEN_W(LEN_W), .END_PG(END_PG), .MAX_FRAME(MAX_FRAME)
  ) u_admit (
    .stop_i    (rx_stop_i),
    .first_pg_i(ring_first_pg_i),
    .last_pg_i (ring_last_pg_i),
    .bnd_pg_i  (bnd_pg_i),
    .cur_pg_i  (cur_q),
    .len_i     (in_len_i),
    .ok_o      (ok),
    .base_pg_o (base_pg),
    .next_pg_o (next_pg)
  );

  rxr_wrap_ctr #(.PG_W(PG_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_addr_i(base_addr + DATA_OFS),
    .step_i     (ctr_step),
    .first_pg_i (ring_first_pg_i),
    .last_pg_i  (ring_last_pg_i),
    .addr_o     (ctr_addr)
  );

  always_comb begin
    unique case (hcnt_q)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = 8'(next_q);
      2'd2:    hdr_byte = tot_q[7:0];
      default: hdr_byte = tot_q[15:8];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      next_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      tot_q   <= '0;
      stat_q  <= '0;
      wdata_q <= '0;
      hcnt_q  <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sof_hit) begin
            if (ok) begin
              we_q    <= 1'b1;
              addr_q  <= base_addr + DATA_OFS;
              wdata_q <= in_data_i;
              base_q  <= base_addr;
              next_q  <= next_pg;
              tot_q   <= HDR_LEN_W'(in_len_i) + HDR_LEN_W'(HDR_BYTES);
              stat_q  <= STAT_GOOD | (in_data_i[0] ? STAT_GROUP : 8'h00);
              hcnt_q  <= '0;
              state_q <= in_eof_i ? ST_HDR : ST_DATA;
            end else begin
              state_q <= in_eof_i ? ST_IDLE : ST_DROP;
            end
          end else if (cur_ld_i && ({1'b0, cur_ld_pg_i} < END_V)) begin
            cur_q <= cur_ld_pg_i;
          end
        end
        ST_DATA: begin
          if (in_valid_i) begin
            we_q    <= 1'b1;
            addr_q  <= ctr_addr;
            wdata_q <= in_data_i;
            if (in_eof_i) state_q <= ST_HDR;
          end
        end
        ST_DROP: begin
          if (in_valid_i && in_eof_i) state_q <= ST_IDLE;
        end
        default: begin
          we_q    <= 1'b1;
          addr_q  <= base_q + ADDR_W'(hcnt_q);
          wdata_q <= hdr_byte;
          hcnt_q  <= hcnt_q + 2'd1;
          if (hcnt_q == 2'd3) begin
            done_q  <= 1'b1;
            cur_q   <= next_q;
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign cur_pg_o    = cur_q;
  assign rx_irq_o    = irq_q;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int unsigned PG_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rx_stop_i,
  input logic            cur_ld_i,
  input logic            in_valid_i,
  input logic            in_sof_i,
  input logic            busy_o,
  input logic            mem_we_o,
  input logic            done_o,
  input logic [PG_W-1:0] cur_pg_o,
  input logic            rx_irq_o
);
  p_we_in_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !done_o) |-> busy_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rx_irq_o);

  p_done_writes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_we_o);

  p_stop_refuse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stop_i && in_valid_i && in_sof_i && !busy_o) |=> !mem_we_o);

  p_cur_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(cur_ld_i)) |-> $stable(cur_pg_o));
endmodule

bind rx_ring_writer rxr_checker #(.PG_W(PG_W)) u_rxr_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_stop_i (rx_stop_i),
  .cur_ld_i  (cur_ld_i),
  .in_valid_i(in_valid_i),
  .in_sof_i  (in_sof_i),
  .busy_o    (busy_o),
  .mem_we_o  (mem_we_o),
  .done_o    (done_o),
  .cur_pg_o  (cur_pg_o),
  .rx_irq_o  (rx_irq_o)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_stop = 1'b0;
  logic [7:0]  first_pg = 8'h40, last_pg = 8'h60, bnd_pg = 8'h40;
  logic        cur_ld = 1'b0;
  logic [7:0]  cur_ld_pg = 8'h00;
  logic        irq_clr = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [15:0] in_len = 16'h0;
  logic        busy_o, mem_we_o, done_o, rx_irq_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, cur_pg_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int cur_e = 0;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  rx_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_stop_i(rx_stop),
    .ring_first_pg_i(first_pg), .ring_last_pg_i(last_pg), .bnd_pg_i(bnd_pg),
    .cur_ld_i(cur_ld), .cur_ld_pg_i(cur_ld_pg), .irq_clr_i(irq_clr),
    .in_valid_i(in_valid), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .in_data_i(in_data), .in_len_i(in_len),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .cur_pg_o(cur_pg_o),
    .rx_irq_o(rx_irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [7:0] b0,
                                       input int seed);
    return (i == 0) ? b0 : 8'(seed + i);
  endfunction

  // per-clock comparison of the write port against the expected write list
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o) n_done++;
      if (mem_we_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R10 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R2/R5/R8 write",
              {mem_addr_o, mem_wdata_o}, e);
        end
      end
    end
  end

  task automatic model_frame(input int len, input logic [7:0] b0,
                             input int seed, output bit acc);
    int f, l, c, b, free, base, tot, nxt, a;
    logic [7:0] st;
    f = first_pg; l = last_pg; c = cur_e; b = bnd_pg;
    if (c < b) free = b - c; else free = (l - f) - (c - b);
    acc = !rx_stop && (l > f) && (free * 256 >= 1518);
    if (!acc) return;
    base = ((c >= 128) ? f : c) * 256;
    tot = len + 4;
    nxt = base + ((tot + 4 + 255) / 256) * 256;
    if (nxt >= l * 256) nxt -= (l - f) * 256;
    a = base + 4;
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({16'(a), fbyte(i, b0, seed)});
      a++;
      if (a == l * 256) a = f * 256;
    end
    st = b0[0] ? 8'h21 : 8'h01;
    exp_q.push_back({16'(base), st});
    exp_q.push_back({16'(base + 1), 8'(nxt / 256)});
    exp_q.push_back({16'(base + 2), 8'(tot)});
    exp_q.push_back({16'(base + 3), 8'(tot / 256)});
    cur_e = nxt / 256;
  endtask

  task automatic run(input int len, input logic [7:0] b0, input int seed,
                     input bit gap, input bit ldmid, input string tag);
    bit acc;
    int d0;
    logic irq0;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    irq0 = rx_irq_o;
    d0 = n_done;
    model_frame(len, b0, seed, acc);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = fbyte(i, b0, seed);
      in_len = 16'(len);
      cur_ld = ldmid && (i == 1);
      cur_ld_pg = 8'h55;
      @(negedge clk);
      if (gap && i == 2) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cur_ld = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cur_ld = 1'b0;
    if (acc) chk(busy_o == 1'b1, {tag, " R10 busy after last byte"}, busy_o, 1);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(cur_pg_o == 8'(cur_e), {tag, " R7/R9 current page"}, cur_pg_o, cur_e);
    chk(exp_q.size() == 0, {tag, " R5/R10 writes missing"}, exp_q.size(), 0);
    if (acc) begin
      chk(rx_irq_o == 1'b1, {tag, " R9 irq set"}, rx_irq_o, 1);
      chk(n_done == d0 + 1, {tag, " R10 one done pulse"}, n_done - d0, 1);
    end else begin
      chk(rx_irq_o == irq0, {tag, " R3/R4 irq unchanged"}, rx_irq_o, irq0);
      chk(n_done == d0, {tag, " R3/R4 no done"}, n_done - d0, 0);
    end
    exp_q.delete();
  endtask

  task automatic load_cur(input logic [7:0] v, input string tag);
    @(negedge clk);
    cur_ld = 1'b1; cur_ld_pg = v;
    @(negedge clk);
    cur_ld = 1'b0;
    if (v < 128) cur_e = v;
    @(negedge clk);
    chk(cur_pg_o == 8'(cur_e), {tag, " R12 load"}, cur_pg_o, cur_e);
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
    chk(rx_irq_o == 1'b0, "R9 irq clear", rx_irq_o, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(mem_we_o == 1'b0, "R1 we", mem_we_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(rx_irq_o == 1'b0, "R1 irq", rx_irq_o, 0);
    chk(cur_pg_o == 8'h00, "R1 cur", cur_pg_o, 0);
    rst_ni = 1'b1;

    load_cur(8'h40, "init");
    run(60, 8'h00, 5, 1'b0, 1'b0, "R2 R6 unicast");
    run(300, 8'h01, 9, 1'b1, 1'b1, "R6 R12 group gap midload");
    clear_irq();

    load_cur(8'h5F, "wrap");
    bnd_pg = 8'h50;
    run(600, 8'h10, 3, 1'b0, 1'b0, "R7 R8 wrap");
    clear_irq();

    load_cur(8'h42, "free");
    bnd_pg = 8'h47;
    run(100, 8'h02, 7, 1'b0, 1'b0, "R4 short space");
    bnd_pg = 8'h48;
    run(100, 8'h02, 7, 1'b0, 1'b0, "R4 exact space");
    clear_irq();

    bnd_pg = 8'h40;
    rx_stop = 1'b1;
    run(50, 8'h00, 1, 1'b0, 1'b0, "R3 stopped");
    rx_stop = 1'b0;
    last_pg = 8'h40;
    run(50, 8'h00, 1, 1'b0, 1'b0, "R3 empty ring");
    last_pg = 8'h60;

    run(1, 8'hFF, 0, 1'b0, 1'b0, "R10 single byte");
    load_cur(8'h80, "R12 out of range");

    last_pg = 8'h90;
    load_cur(8'h7F, "end");
    run(60, 8'h00, 11, 1'b0, 1'b0, "R11 reach end");
    run(60, 8'h00, 13, 1'b0, 1'b0, "R11 past end");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule